// File: doc/BRIEF.md
# Serial Flash Status Register with Write Lock

This block is the command front end of a serial flash slave. It watches a mode-0 serial link (chip select, clock, data in), gathers the first byte of each frame as an opcode and acts on three commands: set the write-enable latch, read the status byte, and write the status byte. The status byte holds a lock flag, a quad flag and the write-enable latch. The block oversamples the serial pins with a fast system clock. The write-protect pin passes through a two-flop synchroniser before the decoder uses it.

Writes to the status byte are refused when the write-protect pin is low and the lock flag is set. This is the hardware-locked condition. Writes are also refused when the write-enable latch is clear. The decoder makes the refusal as soon as the opcode byte is complete. An unknown opcode is treated the same way. In both cases the block goes into a standby state for the rest of the frame: it ignores every further byte and keeps its serial output released. It leaves standby only when chip select falls again. A host uses the block by framing commands under chip select. It reads the status byte back to confirm that a write took effect.

Top module: `sflash_wp_front`

## Requirements
- R1: After reset the status byte reads 0x00 and the serial output enable `spi_miso_oe` is low.
- R2: Opcode 0x05 (read status) shifts the status byte out MSB first. It repeats the byte for every further byte clocked while chip select stays low. The bit layout is: bit 7 = lock flag, bit 6 = quad flag, bit 1 = write-enable latch, and bits 5..2 and 0 read 0.
- R3: Opcode 0x06 (write enable) sets the write-enable latch, which is status bit 1.
- R4: Opcode 0x01 (write status) is accepted when the latch is set and the block is not hardware-locked. Its following data byte then loads the lock flag from data bit 7 and the quad flag from data bit 6, and clears the latch. Data bits 5..0 have no effect.
- R5: A write-status opcode with the latch clear is refused at decode. The status byte is unchanged, and the data byte that follows is ignored.
- R6: When the write-protect pin is low and the lock flag is 1, a write-status opcode is refused even with the latch set. The status byte, including the latch, is left unchanged.
- R7: A write-status opcode is accepted when the lock flag is 1 and the write-protect pin is high. It is also accepted when the write-protect pin is low and the lock flag is 0.
- R8: Any opcode other than 0x01, 0x05 and 0x06 sends the frame to standby. Later bytes in that frame, even valid opcodes, have no effect and never enable the output.
- R9: A falling chip select ends standby, and the next frame is decoded normally.
- R10: `spi_miso_oe` is high only during the data phase of a read-status frame. It is low during every opcode byte and while chip select is high. Output bits change on falling serial clock edges, so they can be sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low; frames are delimited by it |
| spi_sclk | input | 1 | Serial clock, idle low (mode 0) |
| spi_mosi | input | 1 | Serial data from the host, sampled on rising clock |
| wp_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | Serial data to the host, updated on falling clock |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |

## Verification
Write-status attempts are made under all four combinations of pin level and lock flag, and with the latch both set and clear. A read-status frame after each attempt shows whether the attempt was accepted or refused. Refused and unknown-opcode frames carry a trailing 0x05 or 0x06, so a design that went on decoding after a refusal would either drive the output or change the latch. Read frames of two and three data bytes check that the status byte repeats. A data byte of 0xFF checks that only bits 7 and 6 are loaded.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  localparam logic [7:0] OP_WRITE_STAT = 8'h01;
  localparam logic [7:0] OP_READ_STAT  = 8'h05;
  localparam logic [7:0] OP_WR_ENABLE  = 8'h06;

  localparam int LOCK_BIT = 7;
  localparam int QUAD_BIT = 6;
  localparam int WEL_BIT  = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_WR_DATA,
    ST_READ,
    ST_STANDBY,
    ST_DONE
  } dec_state_e;

  function automatic logic [7:0] pack_status(input logic lock, input logic quad, input logic wel);
    logic [7:0] s;
    s = 8'h00;
    s[LOCK_BIT] = lock;
    s[QUAD_BIT] = quad;
    s[WEL_BIT]  = wel;
    return s;
  endfunction

  function automatic logic hw_locked(input logic wp_pin_n, input logic lock);
    return (!wp_pin_n) && lock;
  endfunction

endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  output logic              frame_start,
  output logic              frame_end,
  output logic              fall_evt,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  logic             sclk_prev, cs_prev;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic             rise_evt;

  assign frame_start = cs_prev && !cs_n_s;
  assign frame_end   = !cs_prev && cs_n_s;
  assign rise_evt    = sclk_s && !sclk_prev && !cs_n_s;
  assign fall_evt    = !sclk_s && sclk_prev && !cs_n_s;
  assign byte_valid  = rise_evt && (bit_cnt == CNT_W'(BYTE_W - 1));
  assign byte_data   = {rx_sr[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
      bit_cnt   <= '0;
      rx_sr     <= '0;
    end else begin
      sclk_prev <= sclk_s;
      cs_prev   <= cs_n_s;
      if (frame_start) begin
        bit_cnt <= '0;
      end else if (rise_evt) begin
        rx_sr   <= byte_data;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
  import sflash_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n_s,
  input  logic       frame_start,
  input  logic       frame_end,
  input  logic       fall_evt,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       miso,
  output logic       miso_oe
);
  dec_state_e state;
  logic       lock_q, quad_q, wel_q;
  logic [2:0] out_idx;
  logic [7:0] status;

  logic opcode_seen, wren_hit, wrsr_try, wrsr_ok, wrsr_commit, cmd_reject, rdsr_hit;

  assign status      = pack_status(lock_q, quad_q, wel_q);
  assign opcode_seen = byte_valid && (state == ST_OPCODE);
  assign wren_hit    = opcode_seen && (byte_data == OP_WR_ENABLE);
  assign rdsr_hit    = opcode_seen && (byte_data == OP_READ_STAT);
  assign wrsr_try    = opcode_seen && (byte_data == OP_WRITE_STAT);
  assign wrsr_ok     = wel_q && !hw_locked(wp_n_s, lock_q);
  assign wrsr_commit = byte_valid && (state == ST_WR_DATA);
  assign cmd_reject  = opcode_seen && !wren_hit && !rdsr_hit && !(wrsr_try && wrsr_ok);
  assign miso_oe     = (state == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lock_q  <= 1'b0;
      quad_q  <= 1'b0;
      wel_q   <= 1'b0;
      out_idx <= 3'd7;
      miso    <= 1'b0;
    end else if (frame_end) begin
      state <= ST_IDLE;
    end else if (frame_start) begin
      state <= ST_OPCODE;
    end else begin
      if (wren_hit) begin
        wel_q <= 1'b1;
        state <= ST_DONE;
      end
      if (rdsr_hit) begin
        out_idx <= 3'd7;
        state   <= ST_READ;
      end
      if (wrsr_try && wrsr_ok) state <= ST_WR_DATA;
      if (cmd_reject) state <= ST_STANDBY;
      if (wrsr_commit) begin
        lock_q <= byte_data[LOCK_BIT];
        quad_q <= byte_data[QUAD_BIT];
        wel_q  <= 1'b0;
        state  <= ST_DONE;
      end
      if (fall_evt && state == ST_READ) begin
        miso    <= status[out_idx];
        out_idx <= out_idx - 1'b1;
      end
    end
  end

  a_r3_wren_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wren_hit |=> wel_q);
  a_r4_commit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_commit |-> wel_q);
  a_r4_commit_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_commit |=> !wel_q);
  a_r6_lock_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wrsr_commit |=> $stable(lock_q));
  a_r6_hw_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_seen && !wp_n_s && lock_q) |=> (state != ST_WR_DATA));
  a_r8_standby_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && state == ST_STANDBY && !frame_end && !frame_start) |=> $stable(status));
endmodule

// File: rtl/sflash_wp_front.sv
module sflash_wp_front (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sclk,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic [3:0] pins_s;
  logic       frame_start, frame_end, fall_evt, byte_valid;
  logic [7:0] byte_data;

  sflash_sync #(.WIDTH(4), .RST_VAL(4'b1100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({wp_n, spi_cs_n, spi_sclk, spi_mosi}),
    .q     (pins_s)
  );

  sflash_shifter #(.BYTE_W(8)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_s      (pins_s[2]),
    .sclk_s      (pins_s[1]),
    .mosi_s      (pins_s[0]),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .fall_evt    (fall_evt),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data)
  );

  sflash_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_n_s      (pins_s[3]),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .fall_evt    (fall_evt),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .miso        (spi_miso),
    .miso_oe     (spi_miso_oe)
  );

  a_r10_released_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s[2] |=> !spi_miso_oe);
endmodule

// File: tb/test_sflash_wp_front.sv
module test_sflash_wp_front;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_mosi = 1'b0;
  logic wp_n = 1'b1;
  logic spi_miso, spi_miso_oe;

  int n_chk = 0;
  int n_bad = 0;

  string      q_tag[$];
  bit         q_rd[$];
  logic [7:0] q_val[$];

  int         mon_bits;
  bit         mon_cmd_oe, mon_data_any, mon_data_all;
  logic [7:0] mon_byte;

  always #2 clk = ~clk;

  sflash_wp_front i_sflash_wp_front (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .wp_n(wp_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  task automatic check(input string req, input bit ok, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      wait_clk(HALF);
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  // Driver: pushes the expected result of the frame, then drives it.
  task automatic frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input string tag, input bit rd,
                       input logic [7:0] val);
    q_tag.push_back(tag);
    q_rd.push_back(rd);
    q_val.push_back(val);
    wait_clk(1);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    send_byte(b0);
    if (n > 1) send_byte(b1);
    if (n > 2) send_byte(b2);
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic read_status(input int nbytes, input string tag, input logic [7:0] exp);
    frame(nbytes + 1, 8'h05, 8'h00, 8'h00, tag, 1'b1, exp);
  endtask

  // Monitor: observes the serial pins the way a host would.
  always @(negedge spi_cs_n) begin
    mon_bits = 0;
    mon_cmd_oe = 1'b0;
    mon_data_any = 1'b0;
    mon_data_all = 1'b1;
    mon_byte = 8'h00;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (mon_bits < 8) mon_cmd_oe |= spi_miso_oe;
      else begin
        mon_data_any |= spi_miso_oe;
        mon_data_all &= spi_miso_oe;
        mon_byte = {mon_byte[6:0], spi_miso};
      end
      mon_bits++;
    end
  end

  always @(posedge spi_cs_n) begin
    if (q_tag.size() > 0) begin
      string tag;
      bit rd;
      logic [7:0] val;
      tag = q_tag.pop_front();
      rd  = q_rd.pop_front();
      val = q_val.pop_front();
      check("R10 output off during opcode", !mon_cmd_oe, {7'd0, mon_cmd_oe}, 8'h00);
      if (rd) check(tag, mon_data_all && mon_byte == val, mon_byte, val);
      else if (mon_bits > 8) check(tag, !mon_data_any, {7'd0, mon_data_any}, 8'h00);
    end
  end

  initial begin : watchdog
    wait_clk(150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    wait_clk(5);
    check("R1 output enable after reset", spi_miso_oe == 1'b0, {7'd0, spi_miso_oe}, 8'h00);
    rst_n = 1'b1;
    wait_clk(5);
    check("R10 output off while deselected", spi_miso_oe == 1'b0, {7'd0, spi_miso_oe}, 8'h00);
    read_status(2, "R1 status after reset", 8'h00);
    // R3: write enable then a three-byte read to show repetition (R2)
    frame(1, 8'h06, 8'h00, 8'h00, "R3 write enable frame", 1'b0, 8'h00);
    read_status(3, "R2 R3 latch visible, repeated byte", 8'h02);
    // R4: accepted write with all ones; only bits 7 and 6 land, latch clears
    frame(2, 8'h01, 8'hFF, 8'h00, "R4 accepted write frame", 1'b0, 8'h00);
    read_status(2, "R4 lock and quad loaded, latch cleared", 8'hC0);
    // R5: write without latch; trailing 0x05 must not start a read
    frame(2, 8'h01, 8'h05, 8'h00, "R5 refused frame stays released", 1'b0, 8'h00);
    read_status(1, "R5 status unchanged", 8'hC0);
    // R6: pin low, lock set -> refused even with latch
    wp_n = 1'b0;
    wait_clk(10);
    frame(1, 8'h06, 8'h00, 8'h00, "R3 write enable frame", 1'b0, 8'h00);
    read_status(1, "R6 latch set before locked attempt", 8'hC2);
    frame(2, 8'h01, 8'h05, 8'h00, "R6 locked write stays released", 1'b0, 8'h00);
    read_status(1, "R6 status unchanged under lock", 8'hC2);
    // R7: pin high with lock set -> accepted
    wp_n = 1'b1;
    wait_clk(10);
    frame(2, 8'h01, 8'h40, 8'h00, "R7 write with pin high", 1'b0, 8'h00);
    read_status(1, "R7 accepted with pin high and lock set", 8'h40);
    // R7: pin low with lock clear -> accepted
    wp_n = 1'b0;
    wait_clk(10);
    frame(1, 8'h06, 8'h00, 8'h00, "R3 write enable frame", 1'b0, 8'h00);
    frame(2, 8'h01, 8'h80, 8'h00, "R7 write with pin low", 1'b0, 8'h00);
    read_status(1, "R7 accepted with pin low and lock clear", 8'h80);
    // R8: unknown opcode followed by valid opcodes that must be ignored
    frame(3, 8'h9F, 8'h06, 8'h05, "R8 unknown opcode stays released", 1'b0, 8'h00);
    read_status(1, "R8 R9 ignored write enable, fresh frame decodes", 8'h80);
    frame(3, 8'hA5, 8'h05, 8'h05, "R8 second unknown opcode released", 1'b0, 8'h00);
    read_status(2, "R9 read after standby frame", 8'h80);
    wait_clk(20);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule